// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This unit computes one signed fixed-point multiply-accumulate or multiply-subtract per clock. It takes two 16-bit Q15 operands, a 32-bit signed accumulator and an add/subtract select. It returns the 32-bit saturated result together with an overflow flag. The result matches what the two-step sequential fixed-point arithmetic gives: first a doubled multiply that saturates, then a saturating 32-bit add or subtract.

The first stage forms the signed product, doubles it and detects the one operand pair whose doubled product does not fit. For a subtract it inverts the product bitwise. The second stage computes two sums in parallel. One sum uses the registered product and the other uses the already-saturated product. A small selector then chooses one of these sums or a saturation constant. Because of this split, the normal adder path carries no saturation logic in series.

The unit is fully pipelined. An operation presented with `in_valid` produces its result with `out_valid` exactly two clock edges later, and a new operation can be issued on every cycle.

Top module: `fmac_unit`

## Requirements
- R1: With no overflow of any kind, the result equals accumulator plus (or minus) twice the signed product of the operands, and the flag is 0.
- R2: When both operands are -32768 (raw product 0x40000000), the product saturates to 0x7FFFFFFF and the overflow flag is set.
- R3: When the 32-bit add or subtract overflows, the result saturates by accumulator sign (0x7FFFFFFF if the accumulator is non-negative, 0x80000000 if negative) and the flag is 1.
- R4: With `sub`=1 the doubled product is subtracted from the accumulator; with `sub`=0 it is added.
- R5: When the product saturates but accumulating the saturated value (0x7FFFFFFF added, or subtracted) does not overflow, the result is that exact sum.
- R6: When the product saturates and accumulating the saturated value also overflows, the result saturates by accumulator sign.
- R7: The overflow flag is 1 whenever the product saturated, even if the following sum is in range.
- R8: `out_valid` rises exactly two clock edges after `in_valid` is sampled high, and operations issued on consecutive cycles produce results on consecutive cycles, in order.
- R9: Stage two uses the accumulator value present when the operation was issued, not the value on a later cycle.
- R10: A synchronous active-high reset clears both valid stages, so no result appears for an operation that was still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| op_a | input | 16 | Signed Q15 multiplicand |
| op_b | input | 16 | Signed Q15 multiplier |
| acc_in | input | 32 | Signed accumulator |
| sub | input | 1 | 1 = subtract product, 0 = add |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Saturated result |
| ovf | output | 1 | Overflow flag |

## Verification
Every result is due on the second rising edge after its issue edge. The driver stamps each expected item with that due cycle. The monitor, which samples on the falling edge, fails the item if `out_valid` comes early, comes late or is missing at that cycle. Expected values come from a sequential model that performs the saturating doubled multiply and then the saturating 32-bit add or subtract. This independently cross-checks the three-way selection on directed corner cases, on back-to-back bursts and on random operands. A mid-flight reset discards the queued item, and the bench then confirms that no stray result comes out.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
    localparam int DW = 16;
    localparam int LW = 2 * DW;

    localparam logic [LW-1:0] SAT_POS  = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SAT_NEG  = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] RAW_OVER = {2'b01, {(LW-2){1'b0}}};

    typedef struct packed {
        logic [LW-1:0] addend;
        logic [LW-1:0] acc;
        logic          prod_ovf;
        logic          sub;
    } s1_t;

    typedef enum logic [1:0] {
        PICK_NORMAL  = 2'd0,
        PICK_SATPROD = 2'd1,
        PICK_POS     = 2'd2,
        PICK_NEG     = 2'd3
    } pick_e;

    function automatic logic sign_ovf(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction
endpackage

// File: rtl/fmac_adder.sv
module fmac_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         ovf
);
    always_comb begin
        sum = a + b + {{(W-1){1'b0}}, cin};
        ovf = fmac_pkg::sign_ovf(a[W-1], b[W-1], sum[W-1]);
    end
endmodule

// File: rtl/fmac_prod_stage.sv
module fmac_prod_stage
    import fmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [LW-1:0] acc_in,
    input  logic          sub,
    output s1_t           s1_q,
    output logic          s1_valid
);
    logic signed [LW-1:0] raw;
    logic [LW-1:0]        dbl;
    logic                 povf;
    s1_t                  s1_d;

    always_comb begin
        raw = $signed(op_a) * $signed(op_b);
        povf = (raw == RAW_OVER);
        dbl = {raw[LW-2:0], 1'b0};
        s1_d.addend   = sub ? ~dbl : dbl;
        s1_d.acc      = acc_in;
        s1_d.prod_ovf = povf;
        s1_d.sub      = sub;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= in_valid;
        if (in_valid) s1_q <= s1_d;
    end

    p_sat_prod_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a == SAT_NEG[LW-1:DW] && op_b == SAT_NEG[LW-1:DW]) |=> s1_q.prod_ovf);
    p_issue_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);
endmodule

// File: rtl/fmac_acc_stage.sv
module fmac_acc_stage
    import fmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          s1_valid,
    input  s1_t           s1_q,
    output logic          out_valid,
    output logic [LW-1:0] result,
    output logic          ovf
);
    logic [LW-1:0] sum_norm, sum_sat, sat_addend, res_d;
    logic          ovf_norm, ovf_sat, ovf_d;
    pick_e         pick;

    assign sat_addend = s1_q.sub ? ~SAT_POS : SAT_POS;

    fmac_adder #(.W(LW)) u_add_norm (
        .a(s1_q.acc), .b(s1_q.addend), .cin(s1_q.sub), .sum(sum_norm), .ovf(ovf_norm)
    );
    fmac_adder #(.W(LW)) u_add_sat (
        .a(s1_q.acc), .b(sat_addend), .cin(s1_q.sub), .sum(sum_sat), .ovf(ovf_sat)
    );

    always_comb begin
        ovf_d = s1_q.prod_ovf | ovf_norm;
        if (!ovf_d)                           pick = PICK_NORMAL;
        else if (s1_q.prod_ovf && !ovf_sat)   pick = PICK_SATPROD;
        else if (!s1_q.acc[LW-1])             pick = PICK_POS;
        else                                  pick = PICK_NEG;
        unique case (pick)
            PICK_NORMAL:  res_d = sum_norm;
            PICK_SATPROD: res_d = sum_sat;
            PICK_POS:     res_d = SAT_POS;
            default:      res_d = SAT_NEG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s1_valid;
        if (s1_valid) begin
            result <= res_d;
            ovf    <= ovf_d;
        end
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_q.prod_ovf && !ovf_norm) |=> (!ovf && result == $past(sum_norm)));
    p_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && ovf_norm && !(s1_q.prod_ovf && !ovf_sat)) |=> (result == SAT_POS || result == SAT_NEG));
    p_prod_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_q.prod_ovf) |=> ovf);
    p_stage2_r8: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
    import fmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [LW-1:0] acc_in,
    input  logic          sub,
    output logic          out_valid,
    output logic [LW-1:0] result,
    output logic          ovf
);
    s1_t  s1_q;
    logic s1_valid;

    fmac_prod_stage u_prod (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .sub(sub), .s1_q(s1_q), .s1_valid(s1_valid)
    );

    fmac_acc_stage u_acc (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_q(s1_q),
        .out_valid(out_valid), .result(result), .ovf(ovf)
    );

    p_reset_r10: assert property (@(posedge clk) rst |=> (!s1_valid && !out_valid));
endmodule

// File: tb/tb_fmac_unit.sv
`timescale 1ns/1ps
module tb_fmac_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [31:0] acc_in = '0;
    logic        sub = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf;

    fmac_unit dut (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        int          due;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void model(input logic signed [15:0] a, input logic signed [15:0] b,
                                  input logic signed [31:0] acc, input logic s,
                                  output logic [31:0] r, output logic f);
        longint p, pd, t;
        logic po;
        p  = longint'(a) * longint'(b);
        po = (p == 64'sh40000000);
        pd = po ? 64'sh7FFFFFFF : p * 2;
        t  = s ? longint'(acc) - pd : longint'(acc) + pd;
        f  = po;
        if (t > 64'sh7FFFFFFF)       begin r = 32'h7FFFFFFF; f = 1'b1; end
        else if (t < -64'sh80000000) begin r = 32'h80000000; f = 1'b1; end
        else                         r = t[31:0];
    endfunction

    task automatic issue(input logic [15:0] a, input logic [15:0] b, input logic [31:0] acc,
                         input logic s, input string tag);
        exp_t e;
        model(a, b, acc, s, e.res, e.ovf);
        e.due = cyc + 2;
        e.tag = tag;
        exp_q.push_back(e);
        op_a = a; op_b = b; acc_in = acc; sub = s; in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        op_a = 16'hDEAD; op_b = 16'hBEEF; acc_in = 32'hA5A5A5A5;
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", result, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.due, {e.tag, " R8 latency"}, cyc, e.due);
                    check(result == e.res && ovf == e.ovf, e.tag, {result[30:0], ovf}, {e.res[30:0], e.ovf});
                end
            end else if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
                check(1'b0, {exp_q[0].tag, " R8 missing result"}, cyc, exp_q[0].due);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 reset state", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        issue(16'h4000, 16'h2000, 32'h0, 1'b0, "R1 plain product");
        issue(16'h8000, 16'h8000, 32'h0, 1'b0, "R2 product saturation");
        issue(16'h8000, 16'h8000, -32'sd100, 1'b0, "R5 sat product add in range R7");
        issue(16'h8000, 16'h8000, 32'd0, 1'b1, "R5 sat product subtract in range");
        issue(16'h8000, 16'h8000, 32'd5, 1'b0, "R6 sat product add clamps high");
        issue(16'h8000, 16'h8000, -32'sd5, 1'b1, "R6 sat product subtract clamps low");
        issue(16'h7FFF, 16'h7FFF, 32'h7FFFFFF0, 1'b0, "R3 add overflow high");
        issue(16'h7FFF, 16'h8000, 32'h80000000, 1'b0, "R3 add overflow low");
        issue(16'h7FFF, 16'h7FFF, 32'h80000000, 1'b1, "R3 subtract overflow low");
        issue(16'h8001, 16'h7FFF, 32'h7FFFFFFF, 1'b1, "R3 subtract overflow high");
        issue(16'd3, 16'd4, 32'd100, 1'b1, "R4 subtract");
        issue(16'hFFFD, 16'd4, 32'd100, 1'b0, "R4 add negative product");
        idle(4);

        // R9: accumulator changes every cycle of a back-to-back burst
        for (int i = 0; i < 8; i++)
            issue(16'(i * 1000), 16'h0123, 32'(i * 32'h01000000), i[0], "R9 burst accumulator");
        idle(4);

        // R10: reset while an operation is in flight
        issue(16'd7, 16'd9, 32'd1, 1'b0, "R10 dropped");
        rst = 1'b1; in_valid = 1'b0;
        void'(exp_q.pop_front());
        @(negedge clk);
        check(out_valid == 1'b0, "R10 cleared during reset", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R10 no stray result", {31'd0, out_valid}, 32'd0);
        end

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a, b;
            logic [31:0] acc;
            a = 16'($urandom); b = 16'($urandom); acc = $urandom;
            if (i % 17 == 0) begin a = 16'h8000; b = 16'h8000; end
            if (i % 13 == 0) acc = (i % 2 == 0) ? 32'h7FFFFFFF : 32'h80000000;
            if (i % 5 == 0) idle(1);
            issue(a, b, acc, 1'($urandom), "R1 R4 random");
        end
        idle(6);
        check(exp_q.size() == 0, "R8 all results returned", exp_q.size(), 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule